// File: doc/BRIEF.md
# Page-Zero Address Decoder with Switchable On-Chip RAM

This block sits between the CPU and the page-zero targets. For each access it looks at the 16-bit address, the read and write strobes and the 3-bit operating mode, and picks one target: on-chip ROM, on-chip RAM, the on-chip register field, or external memory. If the access is illegal, it raises an address-error flag. The decode is combinational, so the selects and the error flag are valid in the same cycle as the strobes.

The block also holds one control register at 0xFFF9. Bit 7 of that register switches the 1 KB on-chip RAM window on or off. The bit comes up set after reset. Software can write it and read it back through the same strobes. When the bit is cleared, the RAM window falls through to external memory, except in single-chip mode (mode 7), where an access to the window is an address error.

Top module: `mm_decoder`

## Requirements
- R1: Addresses 0xFF80 to 0xFFFF select the register field (`cs_regs`) in every mode and for either value of the enable bit.
- R2: A synchronous reset sets the RAM enable bit to 1. A read of 0xFFF9 right after reset returns 0x80.
- R3: A write strobe at address 0xFFF9 loads bit 7 of `wr_data` into the enable bit on the rising clock edge, and the new value is visible from the next cycle. The other seven bits of that register always read back as 0. A write to any other address leaves the enable bit unchanged.
- R4: With the enable bit at 1, addresses 0xFB80 to 0xFF7F select the on-chip RAM (`cs_ram`) in every mode. 0xFB7F is not part of the window.
- R5: With the enable bit at 0, in every mode other than 7, an access to 0xFB80 to 0xFF7F selects external memory (`cs_ext`).
- R6: With the enable bit at 0, in mode 7 (3'b111), an access to 0xFB80 to 0xFF7F raises `addr_err` and asserts no chip select.
- R7: The vector area 0x0000 to 0x00FF selects on-chip ROM in modes 2 (3'b010) and 4 (3'b100). It selects external memory in modes 1, 3 and 7 (and in the unused modes 0, 5 and 6).
- R8: Any address outside the vector area, the RAM window and the register field selects on-chip ROM in modes 2 and 4 and external memory in all other modes.
- R9: While `rd_en` or `wr_en` is high, exactly one of `cs_rom`, `cs_ram`, `cs_regs`, `cs_ext` and `addr_err` is 1. When both strobes are low, all five are 0.
- R10: `rd_data` carries the control register only during a read of 0xFFF9. At every other time it is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | 16 | Access address |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data; bit 7 feeds the enable bit |
| mode | input | 3 | Operating mode, binary encoded |
| cs_rom | output | 1 | On-chip ROM select |
| cs_ram | output | 1 | On-chip RAM select |
| cs_regs | output | 1 | Register-field select |
| cs_ext | output | 1 | External memory select |
| addr_err | output | 1 | Address-error flag |
| rd_data | output | 8 | Control-register read data |

## Verification
The bench probes the region edges: 0xFB7F against 0xFB80, 0xFF7F against 0xFF80, and 0x00FF against 0x0100. A decoder with an off-by-one window would send one of these edge bytes to the wrong target. Each region is also tried with the enable bit both set and cleared, in the ROM, expanded and single-chip modes. A design that raised the error flag in every mode, or never raised it, or that let a disabled RAM window hide the register field, fails a specific vector. The directed tests write 0x7F and 0x80 to the control register and also write to a neighbouring address. They catch an enable bit that ignores bit 7, leaks the low bits into the read-back, or reacts to the wrong address. A second reset after clearing the bit checks the reset value.

// File: rtl/memmap_pkg.sv
package memmap_pkg;

    localparam int ADDR_W = 16;
    localparam int DATA_W = 8;
    localparam int MODE_W = 3;

    localparam logic [ADDR_W-1:0] VEC_HI    = 16'h00FF;
    localparam logic [ADDR_W-1:0] REG_BASE  = 16'hFF80;
    localparam int                RAM_BYTES = 1024;
    localparam logic [ADDR_W-1:0] RAM_LO    = REG_BASE - ADDR_W'(RAM_BYTES);
    localparam logic [ADDR_W-1:0] RAM_HI    = REG_BASE - 16'd1;
    localparam logic [ADDR_W-1:0] CTRL_ADDR = 16'hFFF9;
    localparam int                EN_BIT    = 7;

    localparam logic [MODE_W-1:0] MODE_ROM_A  = 3'd2;
    localparam logic [MODE_W-1:0] MODE_ROM_B  = 3'd4;
    localparam logic [MODE_W-1:0] MODE_SINGLE = 3'd7;

    typedef enum logic [1:0] {
        RGN_VEC,
        RGN_RAM,
        RGN_REG,
        RGN_OTHER
    } region_e;

    typedef enum logic [2:0] {
        TGT_NONE,
        TGT_ROM,
        TGT_RAM,
        TGT_REG,
        TGT_EXT,
        TGT_ERR
    } target_e;

    typedef struct packed {
        logic rom;
        logic ram;
        logic regs;
        logic ext;
        logic err;
    } sel_t;

    function automatic logic is_rom_mode(input logic [MODE_W-1:0] m);
        return (m == MODE_ROM_A) || (m == MODE_ROM_B);
    endfunction

    function automatic logic is_single_chip(input logic [MODE_W-1:0] m);
        return m == MODE_SINGLE;
    endfunction

    function automatic sel_t target_to_sel(input target_e t);
        sel_t s;
        s      = '0;
        s.rom  = (t == TGT_ROM);
        s.ram  = (t == TGT_RAM);
        s.regs = (t == TGT_REG);
        s.ext  = (t == TGT_EXT);
        s.err  = (t == TGT_ERR);
        return s;
    endfunction

endpackage

// File: rtl/mm_region_classify.sv
module mm_region_classify
    import memmap_pkg::*;
#(
    parameter int                AW      = ADDR_W,
    parameter logic [AW-1:0]     VEC_TOP = VEC_HI,
    parameter logic [AW-1:0]     RAM_BOT = RAM_LO,
    parameter logic [AW-1:0]     RAM_TOP = RAM_HI,
    parameter logic [AW-1:0]     REG_BOT = REG_BASE
) (
    input  logic [AW-1:0] addr,
    output region_e       region
);

    always_comb begin
        if (addr >= REG_BOT)
            region = RGN_REG;
        else if (addr >= RAM_BOT && addr <= RAM_TOP)
            region = RGN_RAM;
        else if (addr <= VEC_TOP)
            region = RGN_VEC;
        else
            region = RGN_OTHER;
    end

endmodule

// File: rtl/mm_ram_ctrl.sv
module mm_ram_ctrl
    import memmap_pkg::*;
#(
    parameter int            AW    = ADDR_W,
    parameter int            DW    = DATA_W,
    parameter logic [AW-1:0] CADDR = CTRL_ADDR,
    parameter int            EBIT  = EN_BIT
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] addr,
    input  logic          rd_en,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    output logic          ram_en,
    output logic [DW-1:0] rd_data
);

    logic hit;
    assign hit = (addr == CADDR);

    always_ff @(posedge clk) begin
        if (rst)
            ram_en <= 1'b1;
        else if (wr_en && hit)
            ram_en <= wr_data[EBIT];
    end

    always_comb begin
        rd_data = '0;
        if (rd_en && hit)
            rd_data[EBIT] = ram_en;
    end

    AST_EN_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> ram_en);                                          // R2
    AST_EN_WRITE: assert property (@(posedge clk) disable iff (rst)
        (wr_en && hit) |=> (ram_en == $past(wr_data[EBIT])));           // R3
    AST_EN_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && hit) |=> $stable(ram_en));                            // R3

endmodule

// File: rtl/mm_select.sv
module mm_select
    import memmap_pkg::*;
#(
    parameter int MW = MODE_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          active,
    input  region_e       region,
    input  logic [MW-1:0] mode,
    input  logic          ram_en,
    output sel_t          sel
);

    target_e tgt;

    always_comb begin
        tgt = TGT_NONE;
        if (active) begin
            unique case (region)
                RGN_REG: tgt = TGT_REG;
                RGN_RAM: begin
                    if (ram_en)
                        tgt = TGT_RAM;
                    else if (is_single_chip(mode))
                        tgt = TGT_ERR;
                    else
                        tgt = TGT_EXT;
                end
                RGN_VEC, RGN_OTHER:
                    tgt = is_rom_mode(mode) ? TGT_ROM : TGT_EXT;
                default: tgt = TGT_NONE;
            endcase
        end
    end

    assign sel = target_to_sel(tgt);

    AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (rst)
        sel.err |-> (mode == MODE_SINGLE && !ram_en && region == RGN_RAM)); // R6
    AST_RAM_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
        sel.ram |-> ram_en);                                             // R4
    AST_ROM_MODE_ONLY: assert property (@(posedge clk) disable iff (rst)
        sel.rom |-> (mode == MODE_ROM_A || mode == MODE_ROM_B));         // R7

endmodule

// File: rtl/mm_decoder.sv
module mm_decoder
    import memmap_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W,
    parameter int MW = MODE_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] addr,
    input  logic          rd_en,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic [MW-1:0] mode,
    output logic          cs_rom,
    output logic          cs_ram,
    output logic          cs_regs,
    output logic          cs_ext,
    output logic          addr_err,
    output logic [DW-1:0] rd_data
);

    region_e region;
    logic    ram_en;
    sel_t    sel;
    logic    active;

    assign active = rd_en | wr_en;

    mm_region_classify #(.AW(AW)) u_classify (
        .addr   (addr),
        .region (region)
    );

    mm_ram_ctrl #(.AW(AW), .DW(DW)) u_ram_ctrl (
        .clk     (clk),
        .rst     (rst),
        .addr    (addr),
        .rd_en   (rd_en),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .ram_en  (ram_en),
        .rd_data (rd_data)
    );

    mm_select #(.MW(MW)) u_select (
        .clk    (clk),
        .rst    (rst),
        .active (active),
        .region (region),
        .mode   (mode),
        .ram_en (ram_en),
        .sel    (sel)
    );

    assign cs_rom   = sel.rom;
    assign cs_ram   = sel.ram;
    assign cs_regs  = sel.regs;
    assign cs_ext   = sel.ext;
    assign addr_err = sel.err;

    AST_ONE_TARGET: assert property (@(posedge clk) disable iff (rst)
        $countones({cs_rom, cs_ram, cs_regs, cs_ext, addr_err})
            == ((rd_en || wr_en) ? 1 : 0));                              // R9
    AST_REG_FIELD: assert property (@(posedge clk) disable iff (rst)
        ((rd_en || wr_en) && addr >= REG_BASE) |-> cs_regs);             // R1
    AST_RDATA_QUIET: assert property (@(posedge clk) disable iff (rst)
        !(rd_en && addr == CTRL_ADDR) |-> (rd_data == '0));              // R10

endmodule

// File: tb/mm_decoder_tb.sv
module mm_decoder_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 20;

    // vector: {req[3:0], en, mode[2:0], addr[15:0], exp{rom,ram,regs,ext,err}}
    localparam logic [28:0] VECS [NVEC] = '{
        {4'd7, 1'b1, 3'd2, 16'h0000, 5'b10000},  // R7 rom mode vector
        {4'd7, 1'b1, 3'd4, 16'h00FF, 5'b10000},  // R7
        {4'd7, 1'b1, 3'd1, 16'h0080, 5'b00010},  // R7 expanded -> ext
        {4'd7, 1'b1, 3'd3, 16'h0000, 5'b00010},  // R7
        {4'd7, 1'b1, 3'd7, 16'h00FF, 5'b00010},  // R7
        {4'd8, 1'b1, 3'd2, 16'h0100, 5'b10000},  // R8
        {4'd8, 1'b1, 3'd1, 16'h8000, 5'b00010},  // R8
        {4'd8, 1'b1, 3'd4, 16'hFB7F, 5'b10000},  // R8 just below window
        {4'd8, 1'b1, 3'd7, 16'hFB7F, 5'b00010},  // R8
        {4'd4, 1'b1, 3'd1, 16'hFB80, 5'b01000},  // R4 window low edge
        {4'd4, 1'b1, 3'd7, 16'hFF7F, 5'b01000},  // R4 window high edge
        {4'd1, 1'b1, 3'd2, 16'hFF80, 5'b00100},  // R1
        {4'd1, 1'b1, 3'd7, 16'hFFFF, 5'b00100},  // R1
        {4'd5, 1'b0, 3'd2, 16'hFB80, 5'b00010},  // R5
        {4'd5, 1'b0, 3'd1, 16'hFF7F, 5'b00010},  // R5
        {4'd6, 1'b0, 3'd7, 16'hFB80, 5'b00001},  // R6
        {4'd6, 1'b0, 3'd7, 16'hFF7F, 5'b00001},  // R6
        {4'd1, 1'b0, 3'd7, 16'hFF80, 5'b00100},  // R1
        {4'd1, 1'b0, 3'd4, 16'hFFF9, 5'b00100},  // R1
        {4'd5, 1'b0, 3'd0, 16'hFC00, 5'b00010}   // R5 unused mode
    };

    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] addr;
    logic        rd_en, wr_en;
    logic [7:0]  wr_data;
    logic [2:0]  mode;
    logic        cs_rom, cs_ram, cs_regs, cs_ext, addr_err;
    logic [7:0]  rd_data;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mm_decoder u_dut (
        .clk(clk), .rst(rst), .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
        .wr_data(wr_data), .mode(mode), .cs_rom(cs_rom), .cs_ram(cs_ram),
        .cs_regs(cs_regs), .cs_ext(cs_ext), .addr_err(addr_err), .rd_data(rd_data)
    );

    task automatic drive(input logic r, input logic w, input logic [15:0] a,
                         input logic [7:0] d, input logic [2:0] m);
        @(negedge clk);
        rd_en = r; wr_en = w; addr = a; wr_data = d; mode = m;
        #1;
    endtask

    task automatic check_sel(input string req, input logic [4:0] exp);
        logic [4:0] act;
        act = {cs_rom, cs_ram, cs_regs, cs_ext, addr_err};
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s addr=%h mode=%0d sel actual=%b expected=%b",
                     req, addr, mode, act, exp);
        end
    endtask

    task automatic check_data(input string req, input logic [7:0] exp);
        checks++;
        if (rd_data !== exp) begin
            errors++;
            $display("FAIL %s rd_data actual=%h expected=%h", req, rd_data, exp);
        end
    endtask

    task automatic set_en(input logic v);
        drive(1'b0, 1'b1, 16'hFFF9, {v, 7'h00}, 3'd1);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; rd_en = 1'b0; wr_en = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        rst = 1'b1; addr = '0; rd_en = 1'b0; wr_en = 1'b0; wr_data = '0; mode = 3'd1;
        do_reset();

        // R2: enable bit set after reset, readback 0x80
        drive(1'b1, 1'b0, 16'hFFF9, 8'h00, 3'd2);
        check_data("R2", 8'h80);
        // R9: idle strobes select nothing
        drive(1'b0, 1'b0, 16'hFB80, 8'h00, 3'd2);
        check_sel("R9", 5'b00000);
        // R10: read of another register-field address gives 0
        drive(1'b1, 1'b0, 16'hFFF8, 8'h00, 3'd2);
        check_data("R10", 8'h00);
        // R10: write to control address does not drive rd_data
        drive(1'b0, 1'b1, 16'hFFF9, 8'hFF, 3'd2);
        check_data("R10", 8'h00);

        for (int i = 0; i < NVEC; i++) begin
            set_en(VECS[i][24]);
            drive(1'b1, 1'b0, VECS[i][20:5], 8'h00, VECS[i][23:21]);
            check_sel($sformatf("R%0d", VECS[i][28:25]), VECS[i][4:0]);
        end

        // R3: write 0x7F clears bit 7, low bits read as 0
        set_en(1'b1);
        drive(1'b0, 1'b1, 16'hFFF9, 8'h7F, 3'd7);
        drive(1'b1, 1'b0, 16'hFFF9, 8'h00, 3'd7);
        check_data("R3", 8'h00);
        // R3: write 0xFF sets bit 7, low bits still 0
        drive(1'b0, 1'b1, 16'hFFF9, 8'hFF, 3'd7);
        drive(1'b1, 1'b0, 16'hFFF9, 8'h00, 3'd7);
        check_data("R3", 8'h80);
        // R3: write to neighbouring address leaves bit unchanged
        drive(1'b0, 1'b1, 16'hFFF8, 8'h00, 3'd7);
        drive(1'b1, 1'b0, 16'hFFF9, 8'h00, 3'd7);
        check_data("R3", 8'h80);
        drive(1'b0, 1'b1, 16'hFFFA, 8'h00, 3'd7);
        drive(1'b1, 1'b0, 16'hFB80, 8'h00, 3'd7);
        check_sel("R3", 5'b01000);
        // R9: write strobe alone decodes too
        drive(1'b0, 1'b1, 16'h0010, 8'h00, 3'd4);
        check_sel("R9", 5'b10000);
        // R6: write access to disabled window in mode 7 flags error
        set_en(1'b0);
        drive(1'b0, 1'b1, 16'hFD00, 8'h00, 3'd7);
        check_sel("R6", 5'b00001);
        // R2: reset restores enable after it was cleared
        do_reset();
        drive(1'b1, 1'b0, 16'hFFF9, 8'h00, 3'd7);
        check_data("R2", 8'h80);
        drive(1'b1, 1'b0, 16'hFD00, 8'h00, 3'd7);
        check_sel("R2", 5'b01000);

        drive(1'b0, 1'b0, 16'h0000, 8'h00, 3'd1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule